// File: doc/BRIEF.md
# Sampler Configuration Register Loader

This block writes one 8-bit value into a setup register of a switched-capacitor waveform sampling chip. The sampler has two such registers: a configuration register and a write-shift register. Each one is selected through a 4-bit address bus and filled over a serial data and clock pair. The host makes a one-cycle request that names the target and the value. The loader selects the address, shifts the value in most significant bit first, and then parks the bus. A one-cycle done pulse tells the host the load is finished.

The sampling wave inside the chip is never stopped. The domino-enable output follows the host's request at all times. The loader lowers only the write-enable output for as long as a load is in progress. The register being loaded is a plain shift register with no shadow copy. If write enable stayed high, the running wave could advance the write-shift register in the middle of a load and corrupt the value. After the load, write enable returns to the level the host had asked for when the request was taken.

Top module: `sampler_cfg_loader`

## Requirements
- R1: In reset and right after reset, busy, done, ser_clk and ser_dat are 0, smp_addr is the idle code 4'b0000, and wr_en equals host_wen.
- R2: Each load gives exactly 8 rising edges of ser_clk. On the k-th rising edge (k = 1 to 8), ser_dat carries bit 8-k of the requested value, so the most significant bit goes first.
- R3: From the first busy cycle until the strobe cycle, smp_addr is 4'b1100 when req_tgt was 0 (configuration register) and 4'b1101 when req_tgt was 1 (write-shift register).
- R4: wr_en is 0 from the first busy cycle through the cycle in which the address is parked. It is never 1 while ser_clk is high.
- R5: dom_en equals host_den in every cycle, loading or not. Changing host_den during a load does not alter the shifted bits.
- R6: ser_clk has period CLK_DIV system cycles and is low for the first half of each bit and high for the second half. ser_dat is set at the start of each bit, half a period before the rising edge, and holds until that bit ends.
- R7: After the 8th bit ends, smp_addr stays at the target code for one strobe cycle. It then moves to the idle code 4'b0000.
- R8: One cycle after the address is parked, wr_en returns to the host_wen value sampled when the request was accepted. It keeps that value through the following cycle, in which done is 1 for exactly one cycle.
- R9: A request that arrives while busy is 1 is ignored. The load in progress shifts its original value, and no second load starts after done.
- R10: busy rises in the cycle after a request is accepted and stays 1 through the done cycle. It is 0 from the next cycle. A load therefore spans 8*CLK_DIV+5 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-cycle load request, taken only when idle |
| req_tgt | input | 1 | Target: 0 configuration register, 1 write-shift register |
| req_data | input | 8 | Value to load |
| host_wen | input | 1 | Write-enable level the host wants outside of loads |
| host_den | input | 1 | Domino-enable level the host wants |
| smp_addr | output | 4 | Address bus to the sampler |
| ser_dat | output | 1 | Serial data to the sampler |
| ser_clk | output | 1 | Serial clock to the sampler |
| wr_en | output | 1 | Write enable to the sampler |
| dom_en | output | 1 | Domino (sampling wave) enable to the sampler |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse at the end of a load |

## Verification
The assertions check the following in every cycle:
- write enable is low and the address holds a register code whenever the serial clock is high;
- serial data holds while the clock is high;
- done lasts one cycle and occurs only while busy;
- a request made while busy cannot change the latched target.

Some behaviour only the bench's scenarios can show. This covers the bit order and value actually received, and the exact cycle on which the address parks and write enable comes back. It also covers the restore to the level sampled at acceptance rather than the current one, domino enable following the host through a load, and recovery from a reset in the middle of a load.

// File: rtl/sampler_cfg_pkg.sv
// Shared types and address codes for the sampler configuration loader.
// Assumes a 4-bit sampler address bus.
package sampler_cfg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_SHIFT, ST_STROBE, ST_PARK, ST_RESTORE, ST_DONE
    } ld_state_t;

    localparam logic [3:0] ADDR_CFG  = 4'b1100;
    localparam logic [3:0] ADDR_WSR  = 4'b1101;
    localparam logic [3:0] ADDR_IDLE = 4'b0000;
endpackage

// File: rtl/sampler_cfg_sclk_gen.sv
// Serial clock and bit counter for one load.
// Counts only while run is high; the counters clear whenever run is low.
// Assumes DIV is even and at least 2.
module sampler_cfg_sclk_gen #(
    parameter int DIV   = 8,
    parameter int NBITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic bit_end,
    output logic last_bit
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int BW   = (NBITS > 2) ? $clog2(NBITS) : 1;

    logic [CW-1:0] div_cnt;
    logic [BW-1:0] bit_cnt;

    // Advance the divider, and the bit index at the end of each bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
            bit_cnt <= '0;
        end else if (div_cnt == CW'(DIV - 1)) begin
            div_cnt <= '0;
            bit_cnt <= bit_cnt + 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Low for the first half of each bit, high for the second half.
    always_comb sclk     = run && (div_cnt >= CW'(HALF));
    always_comb bit_end  = run && (div_cnt == CW'(DIV - 1));
    always_comb last_bit = bit_end && (bit_cnt == BW'(NBITS - 1));
endmodule

// File: rtl/sampler_cfg_shifter.sv
// Parallel-load shift register that presents the value MSB first.
// Assumes load and shift are never high in the same cycle.
module sampler_cfg_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb
);
    logic [W-1:0] sh_q;

    // Capture on load, move one place toward the MSB on shift.
    always_ff @(posedge clk) begin
        if (!rst_n)     sh_q <= '0;
        else if (load)  sh_q <= din;
        else if (shift) sh_q <= {sh_q[W-2:0], 1'b0};
    end

    always_comb msb = sh_q[W-1];
endmodule

// File: rtl/sampler_cfg_loader.sv
// Loads one value into the sampler's configuration or write-shift register.
// Keeps domino enable at the host's level and lowers write enable for the
// whole load, so the running wave cannot move the register being filled.
// Assumes req is a one-cycle strobe; requests are ignored while busy.
module sampler_cfg_loader
    import sampler_cfg_pkg::*;
#(
    parameter int CLK_DIV = 8,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_tgt,
    input  logic [DATA_W-1:0] req_data,
    input  logic              host_wen,
    input  logic              host_den,
    output logic [3:0]        smp_addr,
    output logic              ser_dat,
    output logic              ser_clk,
    output logic              wr_en,
    output logic              dom_en,
    output logic              busy,
    output logic              done
);
    ld_state_t state;
    logic      tgt_q;
    logic      saved_wen;
    logic      accept;
    logic      run;
    logic      bit_end;
    logic      last_bit;
    logic      sclk_i;
    logic      msb;

    always_comb accept = (state == ST_IDLE) && req;
    always_comb run    = (state == ST_SHIFT);

    sampler_cfg_sclk_gen #(.DIV(CLK_DIV), .NBITS(DATA_W)) sclk_i_gen (
        .clk(clk), .rst_n(rst_n), .run(run),
        .sclk(sclk_i), .bit_end(bit_end), .last_bit(last_bit)
    );

    sampler_cfg_shifter #(.W(DATA_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .load(accept), .shift(bit_end),
        .din(req_data), .msb(msb)
    );

    // Sequence one load from setup through the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tgt_q     <= 1'b0;
            saved_wen <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req) begin
                    state     <= ST_SETUP;
                    tgt_q     <= req_tgt;
                    saved_wen <= host_wen;
                end
                ST_SETUP:   state <= ST_SHIFT;
                ST_SHIFT:   if (last_bit) state <= ST_STROBE;
                ST_STROBE:  state <= ST_PARK;
                ST_PARK:    state <= ST_RESTORE;
                ST_RESTORE: state <= ST_DONE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Drive the sampler pins from the current state.
    always_comb begin
        if (state == ST_SETUP || state == ST_SHIFT || state == ST_STROBE)
            smp_addr = tgt_q ? ADDR_WSR : ADDR_CFG;
        else
            smp_addr = ADDR_IDLE;
        case (state)
            ST_IDLE:              wr_en = host_wen;
            ST_RESTORE, ST_DONE:  wr_en = saved_wen;
            default:              wr_en = 1'b0;
        endcase
        ser_clk = sclk_i;
        ser_dat = run && msb;
        dom_en  = host_den;
        busy    = (state != ST_IDLE);
        done    = (state == ST_DONE);
    end

    // R4
    wr_low_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> !wr_en);
    // R3
    addr_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> (smp_addr == ADDR_CFG || smp_addr == ADDR_WSR));
    // R6
    dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> $stable(ser_dat));
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    // R9
    busy_req_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> $stable(tgt_q));
endmodule

// File: tb/sampler_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module sampler_cfg_loader_tb_top;
    localparam int DIV  = 8;
    localparam int HALF = DIV / 2;
    localparam int NSH  = 8 * DIV;
    localparam int IDX_PARK = NSH + 2;
    localparam int IDX_DONE = NSH + 4;
    localparam logic [3:0] A_IDLE = 4'b0000;

    // {tgt, wen, den, data}
    localparam logic [10:0] VEC [6] = '{
        {1'b0, 1'b1, 1'b1, 8'hA5},
        {1'b1, 1'b1, 1'b1, 8'h3C},
        {1'b0, 1'b0, 1'b1, 8'hFF},
        {1'b1, 1'b0, 1'b0, 8'h00},
        {1'b1, 1'b1, 1'b1, 8'h81},
        {1'b0, 1'b1, 1'b0, 8'h5A}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic req = 0, req_tgt = 0, host_wen = 0, host_den = 0;
    logic [7:0] req_data = 0;
    logic [3:0] smp_addr;
    logic ser_dat, ser_clk, wr_en, dom_en, busy, done;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sampler_cfg_loader #(.CLK_DIV(DIV), .DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_tgt(req_tgt),
        .req_data(req_data), .host_wen(host_wen), .host_den(host_den),
        .smp_addr(smp_addr), .ser_dat(ser_dat), .ser_clk(ser_clk),
        .wr_en(wr_en), .dom_en(dom_en), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // One load with optional mid-load disturbances; checks R2..R10.
    task automatic do_load(input logic tgt, input logic [7:0] val, input logic wen,
                           input logic den, input bit inj_req, input bit flip_den,
                           input bit flip_wen);
        logic [7:0] got = 0;
        int rises = 0, highs = 0, prev = 0;
        int e_addr = 0, e_wen = 0, e_park = 0, e_rest = 0, e_done = 0, e_busy = 0, e_den = 0;
        logic [3:0] code = tgt ? 4'b1101 : 4'b1100;
        @(negedge clk);
        req = 1; req_tgt = tgt; req_data = val; host_wen = wen; host_den = den;
        @(negedge clk);
        req = 0;
        for (int k = 0; k <= IDX_DONE + 3; k++) begin
            if (k == 20 && inj_req) begin req = 1; req_tgt = ~tgt; req_data = ~val; end
            if (k == 21) req = 0;
            if (k == 30 && flip_den) host_den = ~host_den;
            if (k == 10 && flip_wen) host_wen = ~host_wen;
            #0;
            if (dom_en !== host_den) e_den++;
            if (ser_clk && !prev) begin rises++; got = {got[6:0], ser_dat}; end
            if (ser_clk) highs++;
            prev = ser_clk;
            if (k <= IDX_PARK - 1 && smp_addr !== code) e_addr++;
            if (k >= IDX_PARK && smp_addr !== A_IDLE) e_park++;
            if (k <= IDX_PARK && wr_en !== 1'b0) e_wen++;
            if ((k == IDX_PARK + 1 || k == IDX_DONE) && wr_en !== wen) e_rest++;
            if (done !== (k == IDX_DONE)) e_done++;
            if (busy !== (k <= IDX_DONE)) e_busy++;
            @(negedge clk);
        end
        chk(rises == 8, "R2 edge count", rises, 8);
        chk(got == val, "R2 value", got, val);
        chk(e_addr == 0, "R3 target address", e_addr, 0);
        chk(e_wen == 0, "R4 write enable low", e_wen, 0);
        chk(e_den == 0, "R5 domino enable", e_den, 0);
        chk(highs == 8 * HALF, "R6 clock high cycles", highs, 8 * HALF);
        chk(e_park == 0, "R7 parked address", e_park, 0);
        chk(e_rest == 0, "R8 write enable restore", e_rest, 0);
        chk(e_done == 0, "R8 done pulse", e_done, 0);
        chk(e_busy == 0, "R10 busy window", e_busy, 0);
        if (inj_req) chk(e_busy == 0 && got == val, "R9 request ignored", got, val);
        if (flip_wen) chk(wr_en === host_wen, "R8 idle follows host", wr_en, host_wen);
        host_den = den;
    endtask

    initial begin
        host_wen = 1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !ser_clk && !ser_dat, "R1 reset outputs", {busy, done, ser_clk, ser_dat}, 0);
        chk(smp_addr == A_IDLE, "R1 reset address", smp_addr, A_IDLE);
        chk(wr_en == host_wen, "R1 reset write enable", wr_en, host_wen);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && smp_addr == A_IDLE, "R1 after reset", busy, 0);
        for (int i = 0; i < 6; i++)
            do_load(VEC[i][10], VEC[i][7:0], VEC[i][9], VEC[i][8], 0, 0, 0);
        // R9 request while busy
        do_load(1'b0, 8'hC3, 1'b1, 1'b1, 1, 0, 0);
        // R5 domino enable changed mid-load
        do_load(1'b1, 8'h96, 1'b1, 1'b1, 0, 1, 0);
        // R8 restore uses level sampled at acceptance
        do_load(1'b0, 8'h69, 1'b1, 1'b1, 0, 0, 1);
        // R1 reset in the middle of a load
        @(negedge clk);
        host_wen = 1; req = 1; req_tgt = 1; req_data = 8'hF0;
        @(negedge clk);
        req = 0;
        repeat (20) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk(!busy && !ser_clk && smp_addr == A_IDLE && wr_en == host_wen,
            "R1 reset mid-load", {busy, ser_clk, wr_en}, 1);
        repeat (4) @(negedge clk);
        chk(!busy, "R1 stays idle", busy, 0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule